// File: doc/BRIEF.md
# Floating-Point Register File with Control/Status Register

This block stores the architectural floating-point registers of a processor core. It also holds the floating-point control and status word. There are 32 registers of `FLEN` bits. Two read ports return their data combinationally, and one write port commits at the clock edge. A single control/status access port reaches the status word through three addresses. One address covers the 5-bit accrued exception flags, one covers the 3-bit rounding mode, and one covers both fields packed into one word.

Every state change marks the floating-point context as modified. A register-file write or any legal status-register write does this. The block then drives the 2-bit context-state output to the "modified" code and raises a summary bit. Both stay set until the surrounding status logic clears them. An access to any other status address is flagged as illegal and changes nothing. A synchronous reset clears all storage.

Top module: `fp_regfile_csr`

## Requirements
- R1: The file holds 32 registers, each `FLEN` bits wide, selected by a 5-bit index. Each read port returns the stored value of its index combinationally, and the two ports work independently.
- R2: With `wr_en` high, `wr_data` is stored at `wr_idx` on the rising clock edge. A read of the same index in that cycle returns the old value, and the new value is visible from the next cycle.
- R3: With `rst` high at a rising edge, every register, the flags field, the rounding-mode field and the modified indication are cleared to zero (`fs_state` = 2'b00, `sd_bit` = 0).
- R4: Address 0x003 reads as the status word zero-extended to `XLEN`: rounding mode in bits 7..5, flags in bits 4..0, zeros above bit 7. A write there loads both fields from `csr_wdata[7:5]` and `csr_wdata[4:0]`, and write bits above 7 are ignored.
- R5: Address 0x001 reads the flags in bits 4..0 with zeros above. A write there loads only the flags from `csr_wdata[4:0]` and leaves the rounding mode unchanged.
- R6: Address 0x002 reads the rounding mode in bits 2..0 with zeros above. A write there loads only the rounding mode from `csr_wdata[2:0]` and leaves the flags unchanged.
- R7: Rounding-mode values 3'b101, 3'b110 and 3'b111 are stored and read back unchanged, with no legality check.
- R8: From the cycle after a register-file write, or after a legal status write (`csr_en` and `csr_we` high), `fs_state` is 2'b11 and `sd_bit` is 1. Both hold until cleared. If a set and a clear fall in the same cycle, the set wins.
- R9: When `csr_en` is high with an address other than 0x001/0x002/0x003, `csr_illegal` is 1 in that same cycle and `csr_rdata` is zero. A write there changes neither field nor the modified indication.
- R10: A status read (`csr_en` high, `csr_we` low) does not change the modified indication.
- R11: `dirty_clr` high at an edge, with no write in that cycle, returns `fs_state` to 2'b00 and `sd_bit` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx_a | input | 5 | Read port A index |
| rd_data_a | output | FLEN | Read port A data |
| rd_idx_b | input | 5 | Read port B index |
| rd_data_b | output | FLEN | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 5 | Register write index |
| wr_data | input | FLEN | Register write data |
| csr_en | input | 1 | Status access valid |
| csr_we | input | 1 | Status access is a write |
| csr_addr | input | 12 | Status address |
| csr_wdata | input | XLEN | Status write data |
| csr_rdata | output | XLEN | Status read data (current contents) |
| csr_illegal | output | 1 | Access to an unknown status address |
| dirty_clr | input | 1 | Clear the modified indication |
| fs_state | output | 2 | Context state, 2'b11 when modified |
| sd_bit | output | 1 | Modified summary bit |

## Verification
A wrong index decode shows up on a read port in the cycle after the write that should have landed. It shows either as the wrong data or as another register losing its value, which a full sweep of the written entries exposes. A wrong field mask in the status word appears on the next read through one of the other two aliases, since each alias exposes a different slice of the same storage. A lost or spurious modified bit is visible on `fs_state`/`sd_bit` one edge after the triggering access. The bench therefore clears it before each test that depends on it.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  localparam int unsigned NUM_REGS   = 32;
  localparam int unsigned IDX_W      = $clog2(NUM_REGS);
  localparam int unsigned CSR_ADDR_W = 12;
  localparam int unsigned FLAGS_W    = 5;
  localparam int unsigned RMODE_W    = 3;
  localparam int unsigned STATUS_W   = FLAGS_W + RMODE_W;

  localparam logic [CSR_ADDR_W-1:0] ADDR_FLAGS = 12'h001;
  localparam logic [CSR_ADDR_W-1:0] ADDR_RMODE = 12'h002;
  localparam logic [CSR_ADDR_W-1:0] ADDR_WHOLE = 12'h003;

  typedef enum logic [1:0] {
    CTX_OFF     = 2'b00,
    CTX_INITIAL = 2'b01,
    CTX_CLEAN   = 2'b10,
    CTX_DIRTY   = 2'b11
  } ctx_state_e;

  typedef struct packed {
    logic [RMODE_W-1:0] rmode;
    logic [FLAGS_W-1:0] flags;
  } fstatus_t;
endpackage

// File: rtl/fprf_storage.sv
module fprf_storage #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned WIDTH  = 64,
  parameter int unsigned N_RD   = 2,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_RD-1:0][AW-1:0]    rd_idx_i,
  output logic [N_RD-1:0][WIDTH-1:0] rd_data_o,
  input  logic                       wr_en_i,
  input  logic [AW-1:0]              wr_idx_i,
  input  logic [WIDTH-1:0]           wr_data_i
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    assign rd_data_o[p] = mem_q[rd_idx_i[p]];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> mem_q[$past(wr_idx_i)] == $past(wr_data_i)); // R2
endmodule

// File: rtl/fprf_status.sv
module fprf_status
  import fprf_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en_i,
  input  logic                  we_i,
  input  logic [CSR_ADDR_W-1:0] addr_i,
  input  logic [XLEN-1:0]       wdata_i,
  output logic [XLEN-1:0]       rdata_o,
  output logic                  illegal_o,
  output logic                  wrote_o
);
  fstatus_t stat_q;
  logic     hit_flags, hit_rmode, hit_whole, legal;

  assign hit_flags = (addr_i == ADDR_FLAGS);
  assign hit_rmode = (addr_i == ADDR_RMODE);
  assign hit_whole = (addr_i == ADDR_WHOLE);
  assign legal     = hit_flags | hit_rmode | hit_whole;
  assign illegal_o = en_i & ~legal;
  assign wrote_o   = en_i & we_i & legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else if (wrote_o) begin
      if (hit_flags || hit_whole) stat_q.flags <= wdata_i[FLAGS_W-1:0];
      if (hit_rmode) stat_q.rmode <= wdata_i[RMODE_W-1:0];
      if (hit_whole) stat_q.rmode <= wdata_i[STATUS_W-1:FLAGS_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (en_i) begin
      if (hit_flags)      rdata_o[FLAGS_W-1:0]  = stat_q.flags;
      else if (hit_rmode) rdata_o[RMODE_W-1:0]  = stat_q.rmode;
      else if (hit_whole) rdata_o[STATUS_W-1:0] = stat_q;
    end
  end

  AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    illegal_o |=> $stable(stat_q)); // R9
  AST_FLAGS_KEEP_RMODE: assert property (@(posedge clk) disable iff (rst)
    (en_i && we_i && hit_flags) |=> $stable(stat_q.rmode)); // R5
  AST_RMODE_KEEP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (en_i && we_i && hit_rmode) |=> $stable(stat_q.flags)); // R6
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdata_o[XLEN-1:STATUS_W] == '0); // R4
endmodule

// File: rtl/fprf_dirty.sv
module fprf_dirty
  import fprf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       set_i,
  input  logic       clr_i,
  output logic [1:0] fs_o,
  output logic       sd_o
);
  logic dirty_q;

  always_ff @(posedge clk) begin
    if (rst)        dirty_q <= 1'b0;
    else if (set_i) dirty_q <= 1'b1;
    else if (clr_i) dirty_q <= 1'b0;
  end

  assign fs_o = dirty_q ? CTX_DIRTY : CTX_OFF;
  assign sd_o = dirty_q;

  AST_DIRTY_SET: assert property (@(posedge clk) disable iff (rst)
    set_i |=> (fs_o == CTX_DIRTY && sd_o)); // R8
  AST_DIRTY_STICKY: assert property (@(posedge clk) disable iff (rst)
    (sd_o && !clr_i) |=> sd_o); // R8
  AST_DIRTY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> (fs_o == CTX_OFF && !sd_o)); // R11
endmodule

// File: rtl/fp_regfile_csr.sv
module fp_regfile_csr
  import fprf_pkg::*;
#(
  parameter int unsigned FLEN = 64,
  parameter int unsigned XLEN = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [IDX_W-1:0]      rd_idx_a,
  output logic [FLEN-1:0]       rd_data_a,
  input  logic [IDX_W-1:0]      rd_idx_b,
  output logic [FLEN-1:0]       rd_data_b,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [FLEN-1:0]       wr_data,
  input  logic                  csr_en,
  input  logic                  csr_we,
  input  logic [CSR_ADDR_W-1:0] csr_addr,
  input  logic [XLEN-1:0]       csr_wdata,
  output logic [XLEN-1:0]       csr_rdata,
  output logic                  csr_illegal,
  input  logic                  dirty_clr,
  output logic [1:0]            fs_state,
  output logic                  sd_bit
);
  localparam int unsigned N_RD = 2;

  logic [N_RD-1:0][IDX_W-1:0] rd_idx;
  logic [N_RD-1:0][FLEN-1:0]  rd_data;
  logic                       csr_wrote;

  assign rd_idx    = {rd_idx_b, rd_idx_a};
  assign rd_data_a = rd_data[0];
  assign rd_data_b = rd_data[1];

  fprf_storage #(
    .DEPTH(NUM_REGS), .WIDTH(FLEN), .N_RD(N_RD)
  ) u_storage (
    .clk(clk), .rst(rst),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data)
  );

  fprf_status #(.XLEN(XLEN)) u_status (
    .clk(clk), .rst(rst),
    .en_i(csr_en), .we_i(csr_we), .addr_i(csr_addr), .wdata_i(csr_wdata),
    .rdata_o(csr_rdata), .illegal_o(csr_illegal), .wrote_o(csr_wrote)
  );

  fprf_dirty u_dirty (
    .clk(clk), .rst(rst),
    .set_i(wr_en | csr_wrote), .clr_i(dirty_clr),
    .fs_o(fs_state), .sd_o(sd_bit)
  );

  AST_READ_NO_DIRTY: assert property (@(posedge clk) disable iff (rst)
    (!sd_bit && csr_en && !csr_we && !wr_en) |=> !sd_bit); // R10
  AST_FS_SD_PAIR: assert property (@(posedge clk) disable iff (rst)
    sd_bit == (fs_state == 2'b11)); // R8
endmodule

// File: tb/tb_fp_regfile_csr.sv
module tb_fp_regfile_csr;
  localparam int FLEN = 64;
  localparam int XLEN = 64;
  localparam int NV   = 8;
  localparam logic [4:0] V_IDX [NV] = '{5'd0, 5'd31, 5'd1, 5'd30, 5'd15, 5'd16, 5'd7, 5'd24};
  localparam logic [63:0] V_DAT [NV] = '{
    64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001,
    64'h3FF0_0000_0000_0000, 64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_0000_0042,
    64'hA5A5_5A5A_A5A5_5A5A, 64'h7FF8_0000_0000_0000};

  logic clk = 0, rst = 1;
  logic [4:0] rd_idx_a = 0, rd_idx_b = 0, wr_idx = 0;
  logic [FLEN-1:0] rd_data_a, rd_data_b, wr_data = 0;
  logic wr_en = 0, csr_en = 0, csr_we = 0, dirty_clr = 0;
  logic [11:0] csr_addr = 0;
  logic [XLEN-1:0] csr_wdata = 0, csr_rdata;
  logic csr_illegal, sd_bit;
  logic [1:0] fs_state;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  fp_regfile_csr #(.FLEN(FLEN), .XLEN(XLEN)) dut (
    .clk(clk), .rst(rst), .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
    .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .csr_en(csr_en), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
    .dirty_clr(dirty_clr), .fs_state(fs_state), .sd_bit(sd_bit));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rf_write(input logic [4:0] i, input logic [63:0] d);
    wr_en = 1; wr_idx = i; wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic csr_write(input logic [11:0] a, input logic [63:0] d);
    csr_en = 1; csr_we = 1; csr_addr = a; csr_wdata = d; tick();
    csr_en = 0; csr_we = 0;
  endtask

  task automatic csr_read(input logic [11:0] a, output logic [63:0] d);
    csr_en = 1; csr_we = 0; csr_addr = a; #1 d = csr_rdata; csr_en = 0;
  endtask

  task automatic clear_dirty();
    dirty_clr = 1; tick(); dirty_clr = 0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] r;
    tick(); tick(); rst = 0; #1;
    // R3 reset state
    rd_idx_a = 0; rd_idx_b = 31; #1;
    chk("R3 reg0", rd_data_a, 0);
    chk("R3 reg31", rd_data_b, 0);
    csr_read(12'h003, r); chk("R3 fcsr", r, 0);
    chk("R3 fs", {62'b0, fs_state}, 0);
    chk("R3 sd", {63'b0, sd_bit}, 0);

    // R1 R2 table walk
    for (int k = 0; k < NV; k++) begin
      rf_write(V_IDX[k], V_DAT[k]);
      rd_idx_a = V_IDX[k]; rd_idx_b = V_IDX[k]; #1;
      chk("R2 write port A", rd_data_a, V_DAT[k]);
      chk("R1 read port B", rd_data_b, V_DAT[k]);
    end
    for (int k = 0; k < NV; k++) begin
      rd_idx_a = V_IDX[k]; rd_idx_b = V_IDX[NV-1-k]; #1;
      chk("R1 sweep A", rd_data_a, V_DAT[k]);
      chk("R1 sweep B", rd_data_b, V_DAT[NV-1-k]);
    end
    rd_idx_a = 5'd2; #1; chk("R1 untouched", rd_data_a, 0);
    chk("R8 fs after rf write", {62'b0, fs_state}, 64'd3);
    chk("R8 sd after rf write", {63'b0, sd_bit}, 64'd1);

    // R2 same-cycle read/write
    rd_idx_a = 5'd15; wr_en = 1; wr_idx = 5'd15; wr_data = 64'h1111_2222_3333_4444; #1;
    chk("R2 old value same cycle", rd_data_a, V_DAT[4]);
    tick(); wr_en = 0; #1;
    chk("R2 new value next cycle", rd_data_a, 64'h1111_2222_3333_4444);

    // R11 clear, R10 read keeps clean
    clear_dirty();
    chk("R11 fs cleared", {62'b0, fs_state}, 0);
    chk("R11 sd cleared", {63'b0, sd_bit}, 0);
    csr_en = 1; csr_we = 0; csr_addr = 12'h003; tick(); csr_en = 0;
    chk("R10 read no dirty", {63'b0, sd_bit}, 0);

    // R4 whole-word write
    csr_write(12'h003, 64'hFFFF_FFFF_FFFF_FF5A);
    csr_read(12'h003, r); chk("R4 fcsr readback", r, 64'h5A);
    chk("R8 dirty after csr write", {62'b0, fs_state}, 64'd3);

    // R5 flags alias
    clear_dirty();
    csr_write(12'h001, 64'hFFFF_FFFF_FFFF_FFF5);
    csr_read(12'h003, r); chk("R5 flags only", r, 64'h55);
    csr_read(12'h001, r); chk("R5 flags read", r, 64'h15);
    csr_read(12'h002, r); chk("R6 rmode read", r, 64'h2);
    chk("R8 dirty after flags write", {63'b0, sd_bit}, 64'd1);

    // R6 R7 rmode alias with reserved codes
    csr_write(12'h002, 64'hFD);
    csr_read(12'h003, r); chk("R6 rmode only", r, 64'hB5);
    csr_read(12'h002, r); chk("R7 rmode 101", r, 64'h5);
    csr_write(12'h002, 64'h7);
    csr_read(12'h002, r); chk("R7 rmode 111", r, 64'h7);
    csr_write(12'h002, 64'h6);
    csr_read(12'h003, r); chk("R7 rmode 110", r, 64'hD5);

    // R9 illegal address
    clear_dirty();
    csr_en = 1; csr_we = 1; csr_addr = 12'h004; csr_wdata = 64'hFF; #1;
    chk("R9 illegal flag", {63'b0, csr_illegal}, 64'd1);
    chk("R9 illegal rdata", csr_rdata, 0);
    tick(); csr_addr = 12'h000; #1;
    chk("R9 illegal addr0", {63'b0, csr_illegal}, 64'd1);
    tick(); csr_en = 0; csr_we = 0;
    csr_read(12'h003, r); chk("R9 state unchanged", r, 64'hD5);
    chk("R9 no dirty", {63'b0, sd_bit}, 0);
    csr_en = 1; csr_addr = 12'h003; #1;
    chk("R9 legal not flagged", {63'b0, csr_illegal}, 0);
    csr_en = 0;

    // R8 set wins over clear
    dirty_clr = 1; wr_en = 1; wr_idx = 5'd3; wr_data = 64'h9; tick();
    dirty_clr = 0; wr_en = 0;
    chk("R8 set beats clear", {62'b0, fs_state}, 64'd3);

    // R3 reset again
    rst = 1; tick(); rst = 0; #1;
    rd_idx_a = V_IDX[0]; rd_idx_b = 5'd3; #1;
    chk("R3 reg cleared", rd_data_a, 0);
    chk("R3 reg3 cleared", rd_data_b, 0);
    csr_read(12'h003, r); chk("R3 fcsr cleared", r, 0);
    chk("R3 dirty cleared", {63'b0, sd_bit}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule